// File: doc/BRIEF.md
# Zero-Crossing Synchronized PWM Generator

This block drives the gate of a boost converter running in critical conduction mode. In this mode each switching cycle ends when the inductor current returns to zero, so the cycle has no fixed period. A free-running time base counts up from each reload. The PWM output is high from the reload until the count reaches a programmed on-time. The block then waits for the inductor current to cross zero in the negative direction, as reported by an external comparator.

Accepting that crossing has two effects. The running count is latched as the measured length of the cycle that is ending, and a one-cycle valid strobe goes with it. After a programmed ring-down delay, a sync pulse reloads the counter with a phase value, which starts the next cycle close to zero switch voltage.

A blanking window at the start of each cycle hides the positive crossing and any switching noise. A period limit forces a restart when no crossing arrives in time. A software strobe re-arms the event logic at any moment.

Top module: `zcs_pwm_top`

## Requirements
- R1: `cmp_trip` is taken through a two-flop synchronizer, and a falling edge is detected one clock after the change. A fall set up before clock edge N+1 is therefore accepted, if it qualifies, on edge N+3. The value it latches is the counter value in the cycle before that edge, which is N+2 counts after a restart.
- R2: The counter is 0 after reset or a reload to zero and rises by exactly 1 on each clock edge. It changes only through the reloads given in R7 to R10.
- R3: `pwm_o` is high exactly while the counter is below `on_cmp`, so it is high from a reload to zero until the counter reaches `on_cmp`.
- R4: A falling edge is accepted only when the counter is at least `blank_len`. A fall seen while the counter is below `blank_len` is dropped and latches nothing.
- R5: Only falling edges of `cmp_trip` (negative crossings) can be accepted. A rising edge never causes a capture.
- R6: On an accepted edge, `period_cap` updates and `period_cap_vld` is high on the same clock edge. The strobe lasts exactly one cycle, and `period_cap` holds its value between captures.
- R7: The sync pulse falls on the (`sync_dly`+1)-th clock edge after the capture edge. Falling edges that arrive while this delay is pending are ignored.
- R8: When `phase_load_en` is 1, the sync pulse loads the counter with `phase_val`. When it is 0, the sync pulse does not change the counter.
- R9: When the counter equals `period_limit`, the next edge reloads it to 0 and raises `timeout_pls` for exactly one cycle. No capture takes place on that edge.
- R10: A high level on `sw_rearm` at a clock edge reloads the counter to 0, cancels any pending sync and re-arms the edge acceptance. It also suppresses any capture and the timeout on that edge.
- R11: During reset the outputs are `period_cap` = 0, `period_cap_vld` = 0, `timeout_pls` = 0, and `pwm_o` = 1 when `on_cmp` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_trip | input | 1 | Asynchronous comparator level, high while the inductor current is below the zero threshold |
| on_cmp | input | W | On-time compare value |
| blank_len | input | W | Counter value at which the blanking window closes |
| sync_dly | input | W | Ring-down delay from capture to sync, in clocks minus one |
| phase_val | input | W | Counter load value applied by the sync pulse |
| phase_load_en | input | 1 | Enables the counter load by the sync pulse |
| period_limit | input | W | Largest counter value before a forced restart |
| sw_rearm | input | 1 | Software restart and re-arm strobe |
| pwm_o | output | 1 | PWM gate output |
| period_cap | output | W | Counter value latched at the last accepted crossing |
| period_cap_vld | output | 1 | One-cycle strobe that goes with a new capture |
| timeout_pls | output | 1 | One-cycle pulse on a forced restart at the period limit |

## Verification
The vector table drops the comparator level at several counter positions against several blanking lengths. Each case sits one count below, exactly at, or well past the window edge, which separates an accepted crossing from a blanked one and confirms the latched count and the sync timing. Directed cases then hold the comparator low and raise it late, to show that a positive crossing never captures. Others run with a nonzero phase value, with phase loading disabled, and with no crossing at all. These separate a sync that reloads from one that is ignored, and a timeout restart from an event restart. A software re-arm issued during a pending delay, with a nonzero phase value, shows whether the delayed sync is really cancelled.

// File: rtl/zcs_pwm_pkg.sv
// Shared types for the zero-crossing synchronized PWM generator.
package zcs_pwm_pkg;
    // Event qualifier state: waiting for a crossing, or counting the ring-down delay.
    typedef enum logic {
        QS_ARMED = 1'b0,
        QS_DELAY = 1'b1
    } qual_state_e;
endpackage

// File: rtl/zcs_trip_sync.sv
// Synchronizes the asynchronous comparator level and flags its falling edge.
// Assumes: input may change at any time; STAGES >= 2. Flops reset high so a low
// level at reset release appears as a falling edge, which blanking then handles.
module zcs_trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic fall_o
);
    localparam int TOP = STAGES;

    logic [TOP:0] pipe_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[TOP-1:0], trip_i};
        end
    end

    // Falling edge: previous synchronized sample high, current one low.
    assign fall_o = pipe_q[TOP] & ~pipe_q[TOP-1];
endmodule

// File: rtl/zcs_evt_qual.sv
// Qualifies negative-crossing events and schedules the delayed sync pulse.
// Assumes: cnt_i is the time-base count of the current cycle. A restart
// (software or limit) takes priority over acceptance and sync.
module zcs_evt_qual
    import zcs_pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] blank_len_i,
    input  logic [W-1:0] sync_dly_i,
    input  logic [W-1:0] period_limit_i,
    input  logic         sw_rearm_i,
    output logic         accept_o,
    output logic         sync_o,
    output logic         restart_o,
    output logic         timeout_o
);
    qual_state_e  state_q;
    logic [W-1:0] dcnt_q;
    logic         at_limit;
    logic         blank_open;
    logic         delay_done;
    logic         timeout_q;

    // Window and limit decodes from the current count.
    always_comb begin
        at_limit   = (cnt_i == period_limit_i);
        blank_open = (cnt_i < blank_len_i);
        delay_done = (state_q == QS_DELAY) && (dcnt_q == sync_dly_i);
        restart_o  = sw_rearm_i | at_limit;
        accept_o   = (state_q == QS_ARMED) && fall_i && !blank_open && !restart_o;
        sync_o     = delay_done && !restart_o;
    end

    // Arm/delay state and ring-down counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_o) begin
            state_q <= QS_ARMED;
            dcnt_q  <= '0;
        end else if (accept_o) begin
            state_q <= QS_DELAY;
            dcnt_q  <= '0;
        end else if (state_q == QS_DELAY) begin
            if (delay_done) begin
                state_q <= QS_ARMED;
            end else begin
                dcnt_q <= dcnt_q + W'(1);
            end
        end
    end

    // Timeout pulse, aligned with the counter reload it causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= at_limit && !sw_rearm_i;
        end
    end

    assign timeout_o = timeout_q;
endmodule

// File: rtl/zcs_timebase.sv
// Time-base counter, PWM compare and period capture register.
// Assumes: restart_i has priority over sync_i; accept_i never coincides with restart_i.
module zcs_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         sync_i,
    input  logic         phase_en_i,
    input  logic [W-1:0] phase_val_i,
    input  logic [W-1:0] on_cmp_i,
    input  logic         accept_i,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o,
    output logic [W-1:0] cap_o,
    output logic         cap_vld_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cap_q;
    logic         vld_q;

    // Counter: reload on restart, phase load on enabled sync, otherwise count up.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (sync_i && phase_en_i) begin
            cnt_q <= phase_val_i;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // Capture register and its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= accept_i;
            if (accept_i) begin
                cap_q <= cnt_q;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign pwm_o     = (cnt_q < on_cmp_i);
    assign cap_o     = cap_q;
    assign cap_vld_o = vld_q;
endmodule

// File: rtl/zcs_pwm_top.sv
// Critical-conduction-mode PWM whose period ends on a blanked, delayed
// negative current zero crossing. Assumes blank_len exceeds on_cmp.
module zcs_pwm_top #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_trip,
    input  logic [W-1:0] on_cmp,
    input  logic [W-1:0] blank_len,
    input  logic [W-1:0] sync_dly,
    input  logic [W-1:0] phase_val,
    input  logic         phase_load_en,
    input  logic [W-1:0] period_limit,
    input  logic         sw_rearm,
    output logic         pwm_o,
    output logic [W-1:0] period_cap,
    output logic         period_cap_vld,
    output logic         timeout_pls
);
    logic         fall;
    logic         accept;
    logic         sync_pls;
    logic         restart;
    logic [W-1:0] cnt;

    zcs_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (cmp_trip),
        .fall_o (fall)
    );

    zcs_evt_qual #(.W(W)) u_qual (
        .clk            (clk),
        .rst_n          (rst_n),
        .fall_i         (fall),
        .cnt_i          (cnt),
        .blank_len_i    (blank_len),
        .sync_dly_i     (sync_dly),
        .period_limit_i (period_limit),
        .sw_rearm_i     (sw_rearm),
        .accept_o       (accept),
        .sync_o         (sync_pls),
        .restart_o      (restart),
        .timeout_o      (timeout_pls)
    );

    zcs_timebase #(.W(W)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .sync_i      (sync_pls),
        .phase_en_i  (phase_load_en),
        .phase_val_i (phase_val),
        .on_cmp_i    (on_cmp),
        .accept_i    (accept),
        .cnt_o       (cnt),
        .pwm_o       (pwm_o),
        .cap_o       (period_cap),
        .cap_vld_o   (period_cap_vld)
    );
endmodule

// File: rtl/zcs_pwm_chk.sv
// Protocol checks for zcs_pwm_top, attached by bind.
module zcs_pwm_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         sync_pls,
    input logic         restart,
    input logic         phase_load_en,
    input logic [W-1:0] phase_val,
    input logic [W-1:0] blank_len,
    input logic [W-1:0] on_cmp,
    input logic         pwm_o,
    input logic [W-1:0] period_cap,
    input logic         period_cap_vld,
    input logic         timeout_pls
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        period_cap_vld |=> !period_cap_vld);                                   // R6
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_cap_vld |-> $stable(period_cap));                              // R6
    AST_BLANK_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
        period_cap_vld |-> (period_cap >= $past(blank_len)));                  // R4
    AST_TIMEOUT_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pls |-> !period_cap_vld);                                      // R9
    AST_TIMEOUT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pls |-> (cnt == '0));                                          // R9
    AST_PWM_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_pls && on_cmp != '0) |-> pwm_o);                              // R3
    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pls && phase_load_en && !restart) |=> (cnt == $past(phase_val))); // R8
endmodule

bind zcs_pwm_top zcs_pwm_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt            (cnt),
    .sync_pls       (sync_pls),
    .restart        (restart),
    .phase_load_en  (phase_load_en),
    .phase_val      (phase_val),
    .blank_len      (blank_len),
    .on_cmp         (on_cmp),
    .pwm_o          (pwm_o),
    .period_cap     (period_cap),
    .period_cap_vld (period_cap_vld),
    .timeout_pls    (timeout_pls)
);

// File: tb/zcs_pwm_top_tb.sv
module zcs_pwm_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int ON_T       = 10;
    localparam int DLY        = 3;

    typedef struct packed {
        logic [15:0] k;      // ticks after restart before the comparator drops
        logic [15:0] blank;
        logic        acc;
        logic [15:0] cap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd30,  16'd20, 1'b1, 16'd32},
        '{16'd17,  16'd20, 1'b0, 16'd0},
        '{16'd18,  16'd20, 1'b1, 16'd20},
        '{16'd100, 16'd40, 1'b1, 16'd102},
        '{16'd5,   16'd8,  1'b0, 16'd0},
        '{16'd6,   16'd8,  1'b1, 16'd8}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmp_trip = 1'b1;
    logic [W-1:0] on_cmp = W'(ON_T);
    logic [W-1:0] blank_len = 16'd20;
    logic [W-1:0] sync_dly = W'(DLY);
    logic [W-1:0] phase_val = '0;
    logic         phase_load_en = 1'b1;
    logic [W-1:0] period_limit = 16'd1000;
    logic         sw_rearm = 1'b0;
    logic         pwm_o;
    logic [W-1:0] period_cap;
    logic         period_cap_vld;
    logic         timeout_pls;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zcs_pwm_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_trip(cmp_trip), .on_cmp(on_cmp),
        .blank_len(blank_len), .sync_dly(sync_dly), .phase_val(phase_val),
        .phase_load_en(phase_load_en), .period_limit(period_limit),
        .sw_rearm(sw_rearm), .pwm_o(pwm_o), .period_cap(period_cap),
        .period_cap_vld(period_cap_vld), .timeout_pls(timeout_pls)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // After this task the bench sits at the negedge following restart edge E0 (count 0).
    task automatic rearm();
        sw_rearm = 1'b1;
        tick(1);
        sw_rearm = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen;
        // R11: values held in reset
        tick(4);
        check(period_cap_vld == 1'b0, "R11 vld", period_cap_vld, 0);
        check(period_cap == '0, "R11 cap", period_cap, 0);
        check(timeout_pls == 1'b0, "R11 timeout", timeout_pls, 0);
        check(pwm_o == 1'b1, "R11 pwm", pwm_o, 1);
        rst_n = 1'b1;
        tick(3);

        // Table: R1 R4 R6 R7 R2 capture timing, blanking boundary, sync delay
        foreach (VECS[i]) begin
            blank_len = VECS[i].blank;
            rearm();
            tick(int'(VECS[i].k));
            cmp_trip = 1'b0;
            tick(2);
            check(period_cap_vld == 1'b0, "R1 early", period_cap_vld, 0);
            tick(1);
            check(period_cap_vld == VECS[i].acc, "R4 accept", period_cap_vld, VECS[i].acc);
            if (VECS[i].acc)
                check(period_cap == VECS[i].cap, "R1 R2 cap", period_cap, VECS[i].cap);
            tick(1);
            check(period_cap_vld == 1'b0, "R6 pulse", period_cap_vld, 0);
            tick(DLY - 1);
            check(pwm_o == 1'b0, "R7 before sync", pwm_o, 0);
            tick(1);
            check(pwm_o == VECS[i].acc, "R7 sync edge", pwm_o, VECS[i].acc);
            cmp_trip = 1'b1;
            tick(6);
        end
        blank_len = 16'd20;

        // R8: phase value loaded by sync; count 4, on-time 10 -> 6 high cycles
        phase_val = 16'd4;
        rearm();
        tick(30);
        cmp_trip = 1'b0;
        tick(3 + DLY + 1);
        check(pwm_o == 1'b1, "R8 load", pwm_o, 1);
        tick(5);
        check(pwm_o == 1'b1, "R8 last high", pwm_o, 1);
        tick(1);
        check(pwm_o == 1'b0, "R3 falls at compare", pwm_o, 0);
        cmp_trip = 1'b1;
        tick(6);

        // R8 disabled load, then R9 limit restart
        phase_val = '0;
        phase_load_en = 1'b0;
        period_limit = 16'd60;
        rearm();
        tick(30);
        cmp_trip = 1'b0;
        tick(3 + DLY + 1);
        check(pwm_o == 1'b0, "R8 no load", pwm_o, 0);
        tick(60 - 37);
        check(timeout_pls == 1'b0 && pwm_o == 1'b0, "R9 pre", timeout_pls, 0);
        tick(1);
        check(timeout_pls == 1'b1, "R9 timeout", timeout_pls, 1);
        check(pwm_o == 1'b1, "R9 R3 reload", pwm_o, 1);
        check(period_cap_vld == 1'b0, "R9 no cap", period_cap_vld, 0);
        cmp_trip = 1'b1;
        phase_load_en = 1'b1;

        // R9: no crossing at all, periodic restarts every limit+1 edges
        period_limit = 16'd50;
        rearm();
        tick(50);
        check(timeout_pls == 1'b0, "R9 at limit", timeout_pls, 0);
        tick(1);
        check(timeout_pls == 1'b1, "R9 first", timeout_pls, 1);
        tick(1);
        check(timeout_pls == 1'b0, "R9 one cycle", timeout_pls, 0);
        tick(50);
        check(timeout_pls == 1'b1, "R9 second", timeout_pls, 1);
        period_limit = 16'd1000;

        // R5: a late rising edge never captures
        cmp_trip = 1'b0;
        rearm();
        tick(39);
        cmp_trip = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 25; c++) begin
            tick(1);
            if (period_cap_vld) seen = 1'b1;
        end
        check(seen == 1'b0, "R5 rise ignored", seen, 0);

        // R10: re-arm during pending delay cancels the phase load
        phase_val = 16'd5;
        rearm();
        tick(30);
        cmp_trip = 1'b0;
        tick(3);
        check(period_cap_vld == 1'b1, "R10 setup", period_cap_vld, 1);
        rearm();
        tick(8);
        check(pwm_o == 1'b1, "R10 sync cancelled", pwm_o, 1);
        tick(2);
        check(pwm_o == 1'b0, "R10 R2 count", pwm_o, 0);
        cmp_trip = 1'b1;
        tick(4);
        finish_run();
    end
endmodule